// File: doc/BRIEF.md
# SDRAM Single-Burst Read Sequencer

This block runs one complete read from a synchronous DRAM built from two 16-bit devices placed side by side. Together they form a 32-bit data path with two internal banks. A host raises a request that carries a bank, a row and a column. The sequencer accepts it and opens the row with an activate command. On the next cycle it issues a read command with auto-precharge, which closes the row automatically. It then captures a burst of 4 or 8 words, returning each word with a one-cycle valid strobe.

After the last word the sequencer stays silent for a programmable number of precharge-wait cycles, so the device can finish closing the row. It then pulses `done_o` and returns to idle. The burst length, the CAS latency and the wait count are captured together with the address when the request is accepted. Each access therefore runs to completion with the settings it started with. Writes, refresh, mode-register setup and bank interleaving belong to other blocks.

Top module: `sdram_burst_rd`

## Requirements
- R1: During and after reset, with no request pending, the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (NOP), and `ack_o`, `rd_valid_o` and `done_o` are low.
- R2: When the sequencer is idle and `req_i` is high, `ack_o` is high in that same cycle, and bank, row, column and configuration are latched. The next cycle carries ACTIVE (0011) with `sd_ba_o` equal to the bank and `sd_a_o` equal to the row, zero-extended.
- R3: The cycle after ACTIVE carries READ (0101), with `sd_ba_o` equal to the bank. In `sd_a_o`, bit 10 is 1 (auto-precharge), bits 7:0 hold the column, and all other bits are 0.
- R4: `cfg_cl3_i`=0 selects CAS latency 2 and 1 selects 3. If READ is in cycle n, the first word is sampled from `sd_dq_i` at the rising edge that ends cycle n+CL, and it appears on `rd_data_o` with `rd_valid_o` high in cycle n+CL+1.
- R5: `cfg_bl8_i`=0 gives a burst of 4 words and 1 gives 8. The words are sampled on consecutive cycles, and each one is presented with its own one-cycle `rd_valid_o` pulse, in sampling order.
- R6: After the last data cycle the sequencer waits W cycles, where W equals `cfg_tpc_i` and a value of 0 counts as W=1. `done_o` is high for one cycle, in the cycle that follows the last wait cycle, and that cycle is idle.
- R7: Every cycle other than the ACTIVE and READ cycles carries NOP, including every latency, data and precharge-wait cycle.
- R8: A request held high during an access is not acknowledged until the cycle in which `done_o` is high. In that cycle it is acknowledged and a new access begins.
- R9: Changes to the address and configuration inputs after acceptance have no effect on the access in progress.
- R10: `sd_cke_o` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request |
| ack_o | output | 1 | Request accepted this cycle |
| bank_i | input | 1 | Bank address of the request |
| row_i | input | 11 | Row address of the request |
| col_i | input | 8 | Column address of the request |
| cfg_bl8_i | input | 1 | Burst length select: 0 = 4 words, 1 = 8 words |
| cfg_cl3_i | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| cfg_tpc_i | input | 3 | Precharge-wait cycle count (0 acts as 1) |
| rd_data_o | output | 32 | Captured read word |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| done_o | output | 1 | Access complete pulse |
| sd_cke_o | output | 1 | Clock enable, held high |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 1 | Bank select |
| sd_a_o | output | 11 | Multiplexed row/column address |
| sd_dq_i | input | 32 | Read data from both devices |

## Verification
The bench drives a different word in every cycle, so a capture window shifted by one cycle for either CAS latency returns the wrong words instead of repeating the right ones. A burst that is one word short or one word long shows up as a missing or extra valid strobe. A wait field of 0 and a wait field of 7 are both run: a design that counts zero as zero would raise `done` a cycle early, and one with an off-by-one in the wait counter shows up at the maximum. A request held high across a whole access, together with inputs changed right after acceptance, exposes a sequencer that acknowledges while busy or re-reads the live inputs in the middle of a burst.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACT,
      ST_RD,
      ST_LAT,
      ST_DATA,
      ST_WAIT
   } rd_state_e;

   // Command word order: {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP  = 4'b0111;
   localparam logic [3:0] CMD_ACT  = 4'b0011;
   localparam logic [3:0] CMD_READ = 4'b0101;

endpackage

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W   = 1,
   parameter int ROW_W    = 11,
   parameter int COL_W    = 8,
   parameter int TPC_W    = 3,
   parameter int BL_SHORT = 4,
   parameter int BL_LONG  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   output logic              ack_o,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              bl8_i,
   input  logic              cl3_i,
   input  logic [TPC_W-1:0]  tpc_i,
   output rd_state_e         state_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [COL_W-1:0]  col_o,
   output logic              bl8_o,
   output logic              done_o
);

   localparam int BL_CW = $clog2(BL_LONG);
   localparam int CNT_W = (BL_CW > TPC_W) ? BL_CW : TPC_W;

   rd_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic              bl8_q;
   logic              cl3_q;
   logic [TPC_W-1:0]  tpc_q;
   logic              done_q;

   assign ack_o = (st_q == ST_IDLE) && req_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         bank_q <= '0;
         row_q  <= '0;
         col_q  <= '0;
         bl8_q  <= 1'b0;
         cl3_q  <= 1'b0;
         tpc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_i) begin
                  bank_q <= bank_i;
                  row_q  <= row_i;
                  col_q  <= col_i;
                  bl8_q  <= bl8_i;
                  cl3_q  <= cl3_i;
                  tpc_q  <= tpc_i;
                  st_q   <= ST_ACT;
               end
            end
            ST_ACT: st_q <= ST_RD;
            ST_RD: begin
               // latency cycles between READ and first data cycle: CL-1
               cnt_q <= cl3_q ? CNT_W'(1) : '0;
               st_q  <= ST_LAT;
            end
            ST_LAT: begin
               if (cnt_q == '0) begin
                  cnt_q <= bl8_q ? CNT_W'(BL_LONG - 1) : CNT_W'(BL_SHORT - 1);
                  st_q  <= ST_DATA;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt_q == '0) begin
                  cnt_q <= (tpc_q == '0) ? '0 : CNT_W'(tpc_q - 1'b1);
                  st_q  <= ST_WAIT;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WAIT: begin
               if (cnt_q == '0) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = st_q;
   assign bank_o  = bank_q;
   assign row_o   = row_q;
   assign col_o   = col_q;
   assign bl8_o   = bl8_q;
   assign done_o  = done_q;

   // R2: an accepted request leads straight into the activate cycle
   a_r2_act_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> (st_q == ST_ACT));

   // R8: no new acceptance while an access is in flight
   a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA) |=> !ack_o);

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W = 1,
   parameter int ROW_W  = 11,
   parameter int COL_W  = 8,
   parameter int ADDR_W = 11,
   parameter int AP_BIT = 10
) (
   input  rd_state_e         state_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ADDR_W-1:0] a_o
);

   logic [3:0]        cmd;
   logic [ADDR_W-1:0] row_addr;
   logic [ADDR_W-1:0] col_addr;

   always_comb begin
      row_addr = '0;
      row_addr[ROW_W-1:0] = row_i;
      col_addr = '0;
      col_addr[COL_W-1:0] = col_i;
      col_addr[AP_BIT]    = 1'b1;
   end

   always_comb begin
      cmd  = CMD_NOP;
      ba_o = '0;
      a_o  = '0;
      unique case (state_i)
         ST_ACT: begin
            cmd  = CMD_ACT;
            ba_o = bank_i;
            a_o  = row_addr;
         end
         ST_RD: begin
            cmd  = CMD_READ;
            ba_o = bank_i;
            a_o  = col_addr;
         end
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
   assign cke_o = 1'b1;

endmodule

// File: rtl/sdram_beat_cap.sv
module sdram_beat_cap #(
   parameter int DEV_W = 16,
   parameter int N_DEV = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cap_i,
   input  logic [DEV_W*N_DEV-1:0] dq_i,
   output logic [DEV_W*N_DEV-1:0] data_o,
   output logic                   valid_o
);

   logic valid_q;

   for (genvar l = 0; l < N_DEV; l++) begin : g_lane
      logic [DEV_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     lane_q <= '0;
         else if (cap_i) lane_q <= dq_i[l*DEV_W +: DEV_W];
      end
      assign data_o[l*DEV_W +: DEV_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= cap_i;
   end
   assign valid_o = valid_q;

   // R4: each sampled cycle produces a strobe carrying that cycle's bus word
   a_r4_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (valid_o && data_o == $past(dq_i)));

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W   = 1,
   parameter int ROW_W    = 11,
   parameter int COL_W    = 8,
   parameter int ADDR_W   = 11,
   parameter int AP_BIT   = 10,
   parameter int DEV_W    = 16,
   parameter int N_DEV    = 2,
   parameter int TPC_W    = 3,
   parameter int BL_SHORT = 4,
   parameter int BL_LONG  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_i,
   output logic                   ack_o,
   input  logic [BANK_W-1:0]      bank_i,
   input  logic [ROW_W-1:0]       row_i,
   input  logic [COL_W-1:0]       col_i,
   input  logic                   cfg_bl8_i,
   input  logic                   cfg_cl3_i,
   input  logic [TPC_W-1:0]       cfg_tpc_i,
   output logic [DEV_W*N_DEV-1:0] rd_data_o,
   output logic                   rd_valid_o,
   output logic                   done_o,
   output logic                   sd_cke_o,
   output logic                   sd_cs_n_o,
   output logic                   sd_ras_n_o,
   output logic                   sd_cas_n_o,
   output logic                   sd_we_n_o,
   output logic [BANK_W-1:0]      sd_ba_o,
   output logic [ADDR_W-1:0]      sd_a_o,
   input  logic [DEV_W*N_DEV-1:0] sd_dq_i
);

   localparam int BEAT_W = $clog2(BL_LONG) + 1;

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("auto-precharge bit outside address bus");
   end
   if (COL_W > AP_BIT) begin : g_bad_col
      $error("column overlaps auto-precharge bit");
   end
   if (ROW_W > ADDR_W) begin : g_bad_row
      $error("row wider than address bus");
   end
   if (BL_SHORT < 1 || BL_LONG < BL_SHORT) begin : g_bad_bl
      $error("burst lengths out of order");
   end

   rd_state_e         st;
   logic [BANK_W-1:0] bank_l;
   logic [ROW_W-1:0]  row_l;
   logic [COL_W-1:0]  col_l;
   logic              bl8_l;

   sdram_rd_seq #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TPC_W(TPC_W),
      .BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o),
      .bank_i(bank_i), .row_i(row_i), .col_i(col_i),
      .bl8_i(cfg_bl8_i), .cl3_i(cfg_cl3_i), .tpc_i(cfg_tpc_i),
      .state_o(st), .bank_o(bank_l), .row_o(row_l), .col_o(col_l),
      .bl8_o(bl8_l), .done_o(done_o)
   );

   sdram_cmd_enc #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
      .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
   ) enc_i (
      .state_i(st), .bank_i(bank_l), .row_i(row_l), .col_i(col_l),
      .cke_o(sd_cke_o), .cs_n_o(sd_cs_n_o), .ras_n_o(sd_ras_n_o),
      .cas_n_o(sd_cas_n_o), .we_n_o(sd_we_n_o),
      .ba_o(sd_ba_o), .a_o(sd_a_o)
   );

   sdram_beat_cap #(.DEV_W(DEV_W), .N_DEV(N_DEV)) cap_i (
      .clk(clk), .rst_n(rst_n), .cap_i(st == ST_DATA),
      .dq_i(sd_dq_i), .data_o(rd_data_o), .valid_o(rd_valid_o)
   );

   // ---- assertions on the pin level ----
   logic [3:0]        pin_cmd;
   logic [BEAT_W-1:0] beats_q;
   assign pin_cmd = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};

   always_ff @(posedge clk) begin
      if (!rst_n)          beats_q <= '0;
      else if (ack_o)      beats_q <= '0;
      else if (rd_valid_o) beats_q <= beats_q + 1'b1;
   end

   // R3: READ with auto-precharge follows ACTIVE directly
   a_r3_read_follows_act: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_ACT) |=> (pin_cmd == CMD_READ && sd_a_o[AP_BIT]));

   // R7: precharge wait is silent on the command pins
   a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (pin_cmd == CMD_NOP));

   // R5: an access delivers exactly the configured number of words
   a_r5_beat_total: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (beats_q == (bl8_l ? BEAT_W'(BL_LONG) : BEAT_W'(BL_SHORT))));

   // R6: completion is reported only straight after a wait cycle
   a_r6_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(st) == ST_WAIT && !rd_valid_o));

endmodule

// File: tb/sdram_burst_rd_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_rd_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        ack_o;
   logic        bank_i = 1'b0;
   logic [10:0] row_i = '0;
   logic [7:0]  col_i = '0;
   logic        cfg_bl8_i = 1'b0;
   logic        cfg_cl3_i = 1'b0;
   logic [2:0]  cfg_tpc_i = '0;
   logic [31:0] rd_data_o;
   logic        rd_valid_o;
   logic        done_o;
   logic        sd_cke_o, sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
   logic        sd_ba_o;
   logic [10:0] sd_a_o;
   logic [31:0] sd_dq_i = '0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sdram_burst_rd dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o),
      .bank_i(bank_i), .row_i(row_i), .col_i(col_i),
      .cfg_bl8_i(cfg_bl8_i), .cfg_cl3_i(cfg_cl3_i), .cfg_tpc_i(cfg_tpc_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
      .sd_cke_o(sd_cke_o), .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o),
      .sd_cas_n_o(sd_cas_n_o), .sd_we_n_o(sd_we_n_o),
      .sd_ba_o(sd_ba_o), .sd_a_o(sd_a_o), .sd_dq_i(sd_dq_i)
   );

   function automatic logic [31:0] pat(input logic [15:0] seed, input int c);
      return {seed, 8'(c), ~8'(c)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   function automatic logic [3:0] pins();
      return {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
   endfunction

   // One access; cycle 0 is the acceptance cycle
   task automatic access(input logic b, input logic [10:0] r, input logic [7:0] cl_col,
                         input logic bl8, input logic cl3, input logic [2:0] tpc,
                         input bit hold, input bit skip, input bit chg,
                         input logic [15:0] seed);
      int cl = cl3 ? 3 : 2;
      int bl = bl8 ? 8 : 4;
      int w  = (tpc == 0) ? 1 : int'(tpc);
      int d  = 2 + cl + bl + w;
      if (!skip) begin
         @(negedge clk);
         req_i = 1'b1; bank_i = b; row_i = r; col_i = cl_col;
         cfg_bl8_i = bl8; cfg_cl3_i = cl3; cfg_tpc_i = tpc;
         sd_dq_i = pat(seed, 0);
         #1;
         chk("R2 ack on idle request", 32'(ack_o), 32'd1);
      end
      for (int c = 1; c <= d; c++) begin
         @(negedge clk);
         if (!hold) req_i = 1'b0;
         if (chg && c == 1) begin
            // R9: disturb every latched input
            bank_i = ~b; row_i = ~r; col_i = ~cl_col;
            cfg_bl8_i = ~bl8; cfg_cl3_i = ~cl3; cfg_tpc_i = tpc + 3'd3;
         end
         sd_dq_i = pat(seed, c);
         #1;
         if (c == 1) begin
            chk("R2 ACTIVE cmd", 32'(pins()), 32'h3);
            chk("R2 ACTIVE bank", 32'(sd_ba_o), 32'(b));
            chk("R2 ACTIVE row", 32'(sd_a_o), 32'(r));
         end else if (c == 2) begin
            chk("R3 READ cmd", 32'(pins()), 32'h5);
            chk("R3 READ bank", 32'(sd_ba_o), 32'(b));
            chk("R3 READ column with A10", 32'(sd_a_o), 32'h400 | 32'(cl_col));
         end else begin
            chk("R7 NOP outside ACTIVE/READ", 32'(pins()), 32'h7);
         end
         if (c >= 3 + cl && c <= 2 + cl + bl) begin
            chk("R5 valid strobe", 32'(rd_valid_o), 32'd1);
            chk("R4 word timing", rd_data_o, pat(seed, c - 1));
         end else begin
            chk("R5 no stray strobe", 32'(rd_valid_o), 32'd0);
         end
         chk("R6 done timing", 32'(done_o), (c == d) ? 32'd1 : 32'd0);
         chk("R8 ack only when idle", 32'(ack_o), (c == d && hold) ? 32'd1 : 32'd0);
         chk("R10 cke high", 32'(sd_cke_o), 32'd1);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset cmd", 32'(pins()), 32'h7);
      chk("R1 reset ack", 32'(ack_o), 32'd0);
      chk("R1 reset valid", 32'(rd_valid_o), 32'd0);
      chk("R1 reset done", 32'(done_o), 32'd0);
      chk("R10 cke in reset", 32'(sd_cke_o), 32'd1);
      rst_n = 1'b1;
      repeat (2) begin
         @(negedge clk); #1;
         chk("R1 idle cmd", 32'(pins()), 32'h7);
         chk("R1 idle valid", 32'(rd_valid_o), 32'd0);
      end
   endtask

   task automatic t_bl4_cl2();
      access(1'b0, 11'h155, 8'h3c, 1'b0, 1'b0, 3'd2, 0, 0, 0, 16'hA1B2);
   endtask

   task automatic t_bl8_cl3();
      access(1'b1, 11'h7ff, 8'hff, 1'b1, 1'b1, 3'd5, 0, 0, 0, 16'h5A5A);
   endtask

   task automatic t_tpc_zero();
      access(1'b1, 11'h002, 8'h01, 1'b0, 1'b1, 3'd0, 0, 0, 0, 16'h0F0F);
   endtask

   task automatic t_tpc_max();
      access(1'b0, 11'h400, 8'h80, 1'b1, 1'b0, 3'd7, 0, 0, 0, 16'hC3C3);
   endtask

   task automatic t_holdoff();
      access(1'b1, 11'h0aa, 8'h55, 1'b0, 1'b0, 3'd1, 1, 0, 0, 16'h1234);
      access(1'b1, 11'h0aa, 8'h55, 1'b0, 1'b0, 3'd1, 0, 1, 0, 16'h4321);
   endtask

   task automatic t_cfg_change();
      access(1'b0, 11'h123, 8'h9a, 1'b0, 1'b0, 3'd3, 0, 0, 1, 16'hBEEF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL R6 watchdog: actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_bl4_cl2();
      t_bl8_cl3();
      t_tpc_zero();
      t_tpc_max();
      t_holdoff();
      t_cfg_change();
      repeat (2) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule